// File: doc/BRIEF.md
# Bus Transaction Attribute Generator

This block sits between a cache controller and its system bus and produces the attribute sideband for each transaction the controller starts. For every request it decides whether the access is marked global, meaning it targets shared memory and other bus agents must snoop it. It also produces a two-bit replacement-way code, with its own valid flag, so that logic outside the core can follow the state of the internal cache tags.

A request is presented for one clock as `req_i`, together with:

- the transaction kind;
- the burst and cacheable qualifiers;
- the addressing-mode flag;
- the coherence bit from translation;
- the way picked for replacement.

On the next clock edge the block raises `ts_o`, the registered transfer-start strobe, and drives all attributes registered in that same cycle.

A two-state machine sequences the output stage:

- **ST_IDLE**: no transfer start is driven and every attribute is low.
- **ST_ISSUE**: `ts_o` is high and the captured attributes are driven.

The state moves between them as follows:

- **IDLE→ISSUE**: on a request.
- **ISSUE→ISSUE**: on a back-to-back request.
- **ISSUE→IDLE**: on a cycle with no request.
- **IDLE→IDLE**: while no request arrives.

Asynchronous reset forces ST_IDLE.

Top module: `bus_attr_gen`

## Requirements
- R1: An instruction fetch (kind code 0) never has the global attribute set, whatever the addressing mode or coherence bit.
- R2: With `real_mode_i` high, every data access has the global attribute set. The data accesses are read (1), read-with-intent-to-modify (2), write (3) and touch load (6).
- R3: With `real_mode_i` low, the global attribute of a data access (codes 1, 2, 3, 6) equals `coherent_i`.
- R4: Cast-outs (4), snoop pushes (5) and the unused code 7 never have the global attribute set.
- R5: When `set_valid_o` is high, `set_code_o` is the replacement way in binary: 00 for way 0, 01 for way 1, 10 for way 2, 11 for way 3.
- R6: `set_valid_o` is high only for a read (1) or read-with-intent-to-modify (2) that is both burst and cacheable. Writes, touch loads, noncacheable accesses and single-beat accesses give a low flag.
- R7: Whenever `set_valid_o` is low, `set_code_o` is 00.
- R8: The attributes of a request sampled at a clock edge appear on the outputs right after that edge, in the same cycle as `ts_o`. After a clock edge with no request, `ts_o`, `global_o`, `set_valid_o` and `set_code_o` are all low.
- R9: While `rst_n` is low, all outputs are low, and this takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | A transaction starts this cycle |
| kind_i | input | 3 | Transaction kind code (see R1–R4) |
| burst_i | input | 1 | Transaction is a burst |
| cacheable_i | input | 1 | Access is cacheable |
| real_mode_i | input | 1 | Untranslated (real) addressing mode |
| coherent_i | input | 1 | Memory-coherence bit from translation |
| way_i | input | WAY_W (2) | Way chosen for replacement |
| ts_o | output | 1 | Registered transfer-start strobe |
| global_o | output | 1 | Global (snoop-required) attribute |
| set_code_o | output | WAY_W (2) | Replacement-way code |
| set_valid_o | output | 1 | `set_code_o` carries a meaningful value |

## Verification
Every result is due exactly one clock after the edge that samples its request, with no further pipeline stage. The bench therefore drives inputs on a falling edge and checks the outputs on the next falling edge, which falls half a period after the capturing rising edge. Requests are issued back to back so that each check also confirms the previous vector no longer shows. The one exception is reset, which acts at once: the bench checks the outputs a single time step after pulling `rst_n` low, with no clock edge in between.

// File: rtl/bus_attr_pkg.sv
package bus_attr_pkg;

    // Transaction kind codes presented by the cache controller.
    typedef enum logic [2:0] {
        TK_IFETCH  = 3'd0,
        TK_READ    = 3'd1,
        TK_RWITM   = 3'd2,
        TK_WRITE   = 3'd3,
        TK_CASTOUT = 3'd4,
        TK_PUSH    = 3'd5,
        TK_TOUCH   = 3'd6,
        TK_RSVD    = 3'd7
    } txn_kind_e;

    // Output-stage sequencing.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } out_state_e;

    // Classification of a transaction kind.
    typedef struct packed {
        logic is_fetch;    // instruction fetch
        logic is_data;     // data read/write/touch
        logic is_fill;     // read that allocates a line
        logic no_snoop;    // cast-out, push or unused
    } kind_class_t;

endpackage

// File: rtl/bus_attr_kind_decode.sv
module bus_attr_kind_decode
    import bus_attr_pkg::*;
(
    input  logic [2:0]  kind_i,
    output kind_class_t cls_o
);
    txn_kind_e kind;
    assign kind = txn_kind_e'(kind_i);

    always_comb begin
        cls_o = '0;
        unique case (kind)
            TK_IFETCH:  cls_o.is_fetch = 1'b1;
            TK_READ: begin
                cls_o.is_data = 1'b1;
                cls_o.is_fill = 1'b1;
            end
            TK_RWITM: begin
                cls_o.is_data = 1'b1;
                cls_o.is_fill = 1'b1;
            end
            TK_WRITE:   cls_o.is_data  = 1'b1;
            TK_TOUCH:   cls_o.is_data  = 1'b1;
            TK_CASTOUT: cls_o.no_snoop = 1'b1;
            TK_PUSH:    cls_o.no_snoop = 1'b1;
            TK_RSVD:    cls_o.no_snoop = 1'b1;
        endcase
    end

    // The classes partition the kind space.
    always_comb begin
        assert ($countones({cls_o.is_fetch, cls_o.is_data, cls_o.no_snoop}) == 1)
            else $error("kind class not exclusive");
    end
endmodule

// File: rtl/bus_attr_global_rule.sv
module bus_attr_global_rule
    import bus_attr_pkg::*;
(
    input  kind_class_t cls_i,
    input  logic        real_mode_i,
    input  logic        coherent_i,
    output logic        global_o
);
    // Rules are applied in priority order. Fetches and non-snooped
    // traffic are always local; real mode forces data accesses global;
    // otherwise the translation coherence bit decides.
    always_comb begin
        if (cls_i.is_fetch) begin
            global_o = 1'b0;
        end else if (cls_i.no_snoop) begin
            global_o = 1'b0;
        end else if (real_mode_i) begin
            global_o = cls_i.is_data;
        end else begin
            global_o = cls_i.is_data & coherent_i;
        end
    end
endmodule

// File: rtl/bus_attr_set_rule.sv
module bus_attr_set_rule
    import bus_attr_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  kind_class_t      cls_i,
    input  logic             burst_i,
    input  logic             cacheable_i,
    input  logic [WAY_W-1:0] way_i,
    output logic             valid_o,
    output logic [WAY_W-1:0] code_o
);
    assign valid_o = cls_i.is_fill & burst_i & cacheable_i;

    // Gate each bit of the code with the valid term so an invalid
    // code is always zero.
    for (genvar b = 0; b < WAY_W; b++) begin : g_code
        assign code_o[b] = valid_o & way_i[b];
    end
endmodule

// File: rtl/bus_attr_gen.sv
module bus_attr_gen
    import bus_attr_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [2:0]       kind_i,
    input  logic             burst_i,
    input  logic             cacheable_i,
    input  logic             real_mode_i,
    input  logic             coherent_i,
    input  logic [WAY_W-1:0] way_i,
    output logic             ts_o,
    output logic             global_o,
    output logic [WAY_W-1:0] set_code_o,
    output logic             set_valid_o
);
    localparam logic [WAY_W-1:0] CODE_NONE = '0;

    kind_class_t      cls;
    logic             glob_d;
    logic             setv_d;
    logic [WAY_W-1:0] code_d;

    out_state_e state_q, state_d;

    bus_attr_kind_decode u_decode (
        .kind_i (kind_i),
        .cls_o  (cls)
    );

    bus_attr_global_rule u_global (
        .cls_i       (cls),
        .real_mode_i (real_mode_i),
        .coherent_i  (coherent_i),
        .global_o    (glob_d)
    );

    bus_attr_set_rule #(
        .NUM_WAYS (NUM_WAYS),
        .WAY_W    (WAY_W)
    ) u_set (
        .cls_i       (cls),
        .burst_i     (burst_i),
        .cacheable_i (cacheable_i),
        .way_i       (way_i),
        .valid_o     (setv_d),
        .code_o      (code_d)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_i)  state_d = ST_ISSUE;
            ST_ISSUE: if (!req_i) state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register: load the attributes when the next state issues,
    // clear them otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            global_o    <= 1'b0;
            set_valid_o <= 1'b0;
            set_code_o  <= CODE_NONE;
        end else begin
            unique case (state_d)
                ST_ISSUE: begin
                    global_o    <= glob_d;
                    set_valid_o <= setv_d;
                    set_code_o  <= code_d;
                end
                ST_IDLE: begin
                    global_o    <= 1'b0;
                    set_valid_o <= 1'b0;
                    set_code_o  <= CODE_NONE;
                end
            endcase
        end
    end

    assign ts_o = (state_q == ST_ISSUE);

    // Instruction fetches stay local.
    p_fetch_local_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && kind_i == 3'd0) |=> !global_o);

    // Real mode forces data accesses global.
    p_real_global_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && real_mode_i && (kind_i inside {3'd1, 3'd2, 3'd3, 3'd6})) |=> global_o);

    // Translated data accesses follow the coherence bit.
    p_coh_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !real_mode_i && (kind_i inside {3'd1, 3'd2, 3'd3, 3'd6}))
        |=> (global_o == $past(coherent_i)));

    // Non-snooped kinds stay local.
    p_nosnoop_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && kind_i >= 3'd4 && kind_i != 3'd6) |=> !global_o);

    // The code carries the chosen way.
    p_code_way_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && burst_i && cacheable_i && (kind_i inside {3'd1, 3'd2}))
        |=> (set_valid_o && set_code_o == $past(way_i)));

    // Valid only for cacheable burst fills.
    p_valid_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !(burst_i && cacheable_i && (kind_i inside {3'd1, 3'd2}))) |=> !set_valid_o);

    // An invalid code reads zero.
    p_code_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !set_valid_o |-> (set_code_o == CODE_NONE));

    // Strobe follows the request by one cycle.
    p_ts_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> ts_o);

    // No request means no strobe and no attributes.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!ts_o && !global_o && !set_valid_o));
endmodule

// File: tb/tb_bus_attr_gen.sv
module tb_bus_attr_gen;
    localparam int WAY_W = 2;

    // Expected global attribute per kind, indexed by {real_mode, coherent}.
    localparam logic [3:0] GLOB_TAB [8] = '{
        4'b0000, 4'b1110, 4'b1110, 4'b1110,
        4'b0000, 4'b0000, 4'b1110, 4'b0000
    };
    // Kinds that may carry a set-entry code (bit per kind).
    localparam logic [7:0] FILL_KINDS = 8'b0000_0110;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_i = 1'b0;
    logic [2:0]       kind_i = '0;
    logic             burst_i = 1'b0;
    logic             cacheable_i = 1'b0;
    logic             real_mode_i = 1'b0;
    logic             coherent_i = 1'b0;
    logic [WAY_W-1:0] way_i = '0;
    logic             ts_o, global_o, set_valid_o;
    logic [WAY_W-1:0] set_code_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bus_attr_gen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .kind_i      (kind_i),
        .burst_i     (burst_i),
        .cacheable_i (cacheable_i),
        .real_mode_i (real_mode_i),
        .coherent_i  (coherent_i),
        .way_i       (way_i),
        .ts_o        (ts_o),
        .global_o    (global_o),
        .set_code_o  (set_code_o),
        .set_valid_o (set_valid_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit rq, input logic [2:0] k, input bit b, input bit c,
                         input bit rm, input bit coh, input logic [1:0] w);
        req_i = rq; kind_i = k; burst_i = b; cacheable_i = c;
        real_mode_i = rm; coherent_i = coh; way_i = w;
    endtask

    function automatic string glob_req(input logic [2:0] k, input bit rm);
        if (k == 3'd0) return "R1 fetch global";
        if (k == 3'd4 || k == 3'd5 || k == 3'd7) return "R4 nosnoop global";
        return rm ? "R2 real global" : "R3 coherence global";
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        bit          exp_g, exp_v;
        logic [1:0]  exp_c;
        logic [2:0]  pk;
        bit          prm;

        exp_g = 0; exp_v = 0; exp_c = 0; pk = 0; prm = 0;

        // R9: outputs low while in reset
        repeat (3) @(negedge clk);
        check("R9 reset ts", ts_o, 0);
        check("R9 reset global", global_o, 0);
        check("R9 reset set_valid", set_valid_o, 0);
        check("R9 reset set_code", set_code_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: every kind x mode x coherence x burst x cacheable, back to back
        for (int i = 0; i <= 128; i++) begin
            if (i > 0) begin
                check("R8 ts with attributes", ts_o, 1);
                check(glob_req(pk, prm), global_o, exp_g);
                check("R6 set valid", set_valid_o, exp_v);
                check(exp_v ? "R5 set code" : "R7 code zero", set_code_o, exp_c);
            end
            if (i < 128) begin
                logic [2:0] k;
                logic [1:0] w;
                bit rm, coh, b, c;
                k = 3'(i >> 4);
                rm = i[3]; coh = i[2]; b = i[1]; c = i[0];
                w = 2'(i) ^ 2'(i >> 4);
                drive(1, k, b, c, rm, coh, w);
                pk = k; prm = rm;
                exp_g = GLOB_TAB[k][{rm, coh}];
                exp_v = FILL_KINDS[k] & b & c;
                exp_c = exp_v ? w : 2'b00;
            end else begin
                drive(0, 3'd1, 1, 1, 1, 1, 2'd3);
            end
            @(negedge clk);
        end

        // R8: edge with no request clears everything
        check("R8 idle ts", ts_o, 0);
        check("R8 idle global", global_o, 0);
        check("R8 idle set_valid", set_valid_o, 0);
        check("R8 idle set_code", set_code_o, 0);

        // R5: each way value on a cacheable burst RWITM
        for (int w = 0; w < 4; w++) begin
            drive(1, 3'd2, 1, 1, 0, 0, 2'(w));
            @(negedge clk);
            check("R5 way code", set_code_o, w);
            check("R3 translated noncoherent", global_o, 0);
        end

        // R9: reset mid-stream takes effect without a clock edge
        drive(1, 3'd1, 1, 1, 1, 1, 2'd2);
        @(negedge clk);
        check("R5 before reset", set_code_o, 2);
        rst_n = 1'b0;
        #1;
        check("R9 async ts", ts_o, 0);
        check("R9 async global", global_o, 0);
        check("R9 async set_code", set_code_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(0, 3'd0, 0, 0, 0, 0, 2'd0);
        @(negedge clk);
        check("R8 after reset quiet", ts_o, 0);

        finish_run();
    end
endmodule